// File: doc/BRIEF.md
# Audio Channel Status Block Inserter

This block makes the channel-status bit and the block-start flag for each outgoing audio frame. It counts frames over a repeating block of 192. A one-cycle strobe marks each audio frame. For every strobe the block registers one output word: a valid pulse, a start flag that is high on the first frame of a block, and one status bit for each of the eight audio channels.

When regeneration is enabled, the status bits come from a 184-bit host register. This covers frames 0 to 183. The block then computes a CRC-8 over those bits and sends it on the last eight frames of the block. Every channel gets the same bit in a given frame. When regeneration is off, each channel's incoming status bit passes through unchanged. The start flag is still produced from the frame count.

The host requests an update with an apply pulse. The block then raises a wait flag. At the next block boundary it copies the host register into a shadow copy and drops the wait flag. Host writes made without an apply, or made while a block is being sent, never disturb the block on the wire.

Top module: `acs_inserter`

## Requirements
- R1: While reset is high, and in the cycle after it falls, out_valid, z_out, c_out and apply_wait are 0. Reset also sets the in-block frame position to 0 and clears the shadow copy to all zeros.
- R2: A frame_valid strobe in cycle t gives out_valid = 1 in cycle t+1. A cycle with no strobe gives out_valid = 0, z_out = 0 and c_out = 0 in the following cycle.
- R3: z_out is 1 on the output of the frame at in-block position 0. This is the first strobe after reset and then every 192nd strobe. On all other frames z_out is 0.
- R4: If regen_en is 0 in the strobe cycle, c_out equals the c_in sampled in that cycle, bit for bit per channel.
- R5: If regen_en is 1 in the strobe cycle and the frame is at position k, with k from 0 to 183, every bit of c_out equals shadow bit k. Shadow bit 8*j+i holds bit i of status byte j.
- R6: If regen_en is 1 and the frame is at position k, with k from 184 to 191, every bit of c_out equals bit (k-184) of the CRC. The CRC starts at 8'hFF. It takes in shadow bits 0 to 183 in that order. For each bit b: f = b XOR crc[7], then crc = crc << 1, then crc is XORed with 8'h1D if f is 1.
- R7: An apply pulse in a cycle that is not a boundary cycle sets apply_wait to 1 from the next cycle on. A boundary cycle is a strobe at position 191. apply_wait stays 1 until a boundary cycle and reads 0 in the cycle after it.
- R8: At a boundary cycle with an update pending, the shadow copy takes the host_reg value present in that cycle. The new contents are used from the next block on. Changes to host_reg without an apply have no effect on the output.
- R9: An apply pulse in a boundary cycle is taken at that boundary. apply_wait never rises, and the next block already uses the new contents.
- R10: regen_en is sampled anew on every frame. Turning it off for some frames inside a block gives pass-through on exactly those frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One-cycle strobe per audio frame |
| c_in | input | NUM_CH | Incoming status bit per channel |
| regen_en | input | 1 | Use host-programmed status instead of c_in |
| apply | input | 1 | Pulse requesting load of host_reg at next boundary |
| host_reg | input | STATUS_BITS | Host-programmed status bits, byte 0 in bits 7:0 |
| out_valid | output | 1 | Output word valid, one cycle after a strobe |
| z_out | output | 1 | Block-start flag |
| c_out | output | NUM_CH | Outgoing status bit per channel |
| apply_wait | output | 1 | Update pending, waiting for boundary |

## Verification
A frame counter that is off by one moves the z_out pulse away from a 192-frame spacing. The same error shifts the regenerated bits by one position, so the fault shows on the first block after the slip. A corrupted shadow copy or CRC accumulator shows as a wrong c_out bit within the same block. A CRC fault may only appear on the last eight frames, up to 192 strobes later. A wrong pending state shows on apply_wait in the cycle after an apply or a boundary. It also shows as a whole block sent with stale or early contents.

// File: rtl/acs_pkg.sv
package acs_pkg;

    localparam int unsigned CRC_W    = 8;
    localparam logic [7:0]  CRC_POLY = 8'h1D;
    localparam logic [7:0]  CRC_INIT = 8'hFF;

    // Registered common part of one output frame word
    typedef struct packed {
        logic valid;
        logic z;
        logic stat;
    } frame_word_t;

    // Source selected for the status bit of the current frame
    typedef enum logic [1:0] {
        SRC_PASS = 2'd0,
        SRC_DATA = 2'd1,
        SRC_CRC  = 2'd2
    } stat_src_e;

    // One bit of the serial CRC-8, most significant bit feeds back
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                   input logic            din);
        logic fb;
        logic [CRC_W-1:0] nxt;
        fb  = din ^ cur[CRC_W-1];
        nxt = {cur[CRC_W-2:0], 1'b0};
        if (fb) nxt = nxt ^ CRC_POLY;
        return nxt;
    endfunction

endpackage

// File: rtl/acs_frame_counter.sv
module acs_frame_counter #(
    parameter int unsigned BLOCK_FRAMES = 192,
    localparam int unsigned IW = $clog2(BLOCK_FRAMES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_valid,
    output logic [IW-1:0] pos,
    output logic          first,
    output logic          last
);

    logic [IW-1:0] pos_q;

    assign first = (pos_q == '0);
    assign last  = (pos_q == IW'(BLOCK_FRAMES - 1));
    assign pos   = pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (frame_valid) begin
            pos_q <= last ? '0 : pos_q + IW'(1);
        end
    end

endmodule

// File: rtl/acs_apply_ctrl.sv
module acs_apply_ctrl #(
    parameter int unsigned STATUS_BITS = 184
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   apply,
    input  logic                   boundary,
    input  logic [STATUS_BITS-1:0] host_reg,
    output logic                   pending,
    output logic [STATUS_BITS-1:0] shadow
);

    logic pend_q;
    logic pend_n;
    logic load;
    logic [STATUS_BITS-1:0] shadow_q;

    assign pend_n  = pend_q | apply;
    assign load    = boundary & pend_n;
    assign pending = pend_q;
    assign shadow  = shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            shadow_q <= '0;
        end else begin
            pend_q <= load ? 1'b0 : pend_n;
            if (load) shadow_q <= host_reg;
        end
    end

endmodule

// File: rtl/acs_crc_gen.sv
module acs_crc_gen
    import acs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_valid,
    input  logic             first,
    input  logic             in_data,
    input  logic             data_bit,
    output logic [CRC_W-1:0] crc
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] base;

    // A new block restarts the accumulation from the seed
    assign base = first ? CRC_INIT : crc_q;
    assign crc  = crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_INIT;
        end else if (frame_valid && in_data) begin
            crc_q <= crc_step(base, data_bit);
        end
    end

endmodule

// File: rtl/acs_inserter.sv
module acs_inserter
    import acs_pkg::*;
#(
    parameter int unsigned NUM_CH       = 8,
    parameter int unsigned BLOCK_FRAMES = 192,
    parameter int unsigned STATUS_BITS  = 184
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_valid,
    input  logic [NUM_CH-1:0]      c_in,
    input  logic                   regen_en,
    input  logic                   apply,
    input  logic [STATUS_BITS-1:0] host_reg,
    output logic                   out_valid,
    output logic                   z_out,
    output logic [NUM_CH-1:0]      c_out,
    output logic                   apply_wait
);

    localparam int unsigned IW       = $clog2(BLOCK_FRAMES);
    localparam int unsigned CRC_BITS = BLOCK_FRAMES - STATUS_BITS;
    localparam int unsigned CRC_IW   = $clog2(CRC_BITS);

    logic [IW-1:0]          pos;
    logic                   blk_first;
    logic                   blk_last;
    logic [STATUS_BITS-1:0] shadow_q;
    logic [CRC_W-1:0]       crc_val;
    logic                   in_data;
    logic [IW-1:0]          data_idx;
    logic                   data_bit;
    logic [CRC_IW-1:0]      crc_off;
    stat_src_e              src;
    logic                   stat_bit;
    frame_word_t            word_q;
    logic [NUM_CH-1:0]      c_q;

    acs_frame_counter #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .frame_valid(frame_valid),
        .pos        (pos),
        .first      (blk_first),
        .last       (blk_last)
    );

    acs_apply_ctrl #(.STATUS_BITS(STATUS_BITS)) u_apply (
        .clk     (clk),
        .rst     (rst),
        .apply   (apply),
        .boundary(frame_valid & blk_last),
        .host_reg(host_reg),
        .pending (apply_wait),
        .shadow  (shadow_q)
    );

    assign in_data  = (pos < IW'(STATUS_BITS));
    assign data_idx = in_data ? pos : '0;
    assign data_bit = shadow_q[data_idx];
    assign crc_off  = CRC_IW'(pos - IW'(STATUS_BITS));

    acs_crc_gen u_crc (
        .clk        (clk),
        .rst        (rst),
        .frame_valid(frame_valid),
        .first      (blk_first),
        .in_data    (in_data),
        .data_bit   (data_bit),
        .crc        (crc_val)
    );

    always_comb begin
        if (!regen_en)    src = SRC_PASS;
        else if (in_data) src = SRC_DATA;
        else              src = SRC_CRC;
    end

    always_comb begin
        unique case (src)
            SRC_DATA: stat_bit = data_bit;
            SRC_CRC:  stat_bit = crc_val[crc_off];
            default:  stat_bit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            c_q    <= '0;
        end else begin
            word_q.valid <= frame_valid;
            word_q.z     <= frame_valid & blk_first;
            word_q.stat  <= frame_valid & stat_bit;
            if (!frame_valid)          c_q <= '0;
            else if (src == SRC_PASS)  c_q <= c_in;
            else                       c_q <= {NUM_CH{stat_bit}};
        end
    end

    assign out_valid = word_q.valid;
    assign z_out     = word_q.z;
    assign c_out     = c_q;

endmodule

// File: rtl/acs_inserter_chk.sv
module acs_inserter_chk #(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned STATUS_BITS = 184
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   frame_valid,
    input logic [NUM_CH-1:0]      c_in,
    input logic                   regen_en,
    input logic                   apply,
    input logic [STATUS_BITS-1:0] host_reg,
    input logic                   out_valid,
    input logic                   z_out,
    input logic [NUM_CH-1:0]      c_out,
    input logic                   apply_wait,
    input logic [STATUS_BITS-1:0] shadow_q,
    input logic                   blk_last
);

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> out_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |=> (!out_valid && !z_out && c_out == '0));

    p_z_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
        z_out |-> out_valid);

    p_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && !regen_en) |=> (c_out == $past(c_in)));

    p_same_ch_r5: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && regen_en) |=> (c_out == '0 || c_out == '1));

    p_wait_rise_r7: assert property (@(posedge clk) disable iff (rst)
        (apply && !(frame_valid && blk_last)) |=> apply_wait);

    p_wait_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (apply_wait && frame_valid && blk_last) |=> !apply_wait);

    p_shadow_load_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && blk_last && (apply_wait || apply)) |=> (shadow_q == $past(host_reg)));

    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(frame_valid && blk_last) |=> $stable(shadow_q));

endmodule

bind acs_inserter acs_inserter_chk #(
    .NUM_CH     (NUM_CH),
    .STATUS_BITS(STATUS_BITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_valid(frame_valid),
    .c_in       (c_in),
    .regen_en   (regen_en),
    .apply      (apply),
    .host_reg   (host_reg),
    .out_valid  (out_valid),
    .z_out      (z_out),
    .c_out      (c_out),
    .apply_wait (apply_wait),
    .shadow_q   (shadow_q),
    .blk_last   (blk_last)
);

// File: tb/acs_inserter_tb.sv
module acs_inserter_tb;

    localparam int NCH = 8;
    localparam int NF  = 192;
    localparam int NS  = 184;

    logic           clk = 1'b0;
    logic           rst;
    logic           frame_valid;
    logic [NCH-1:0] c_in;
    logic           regen_en;
    logic           apply;
    logic [NS-1:0]  host_reg;
    logic           out_valid;
    logic           z_out;
    logic [NCH-1:0] c_out;
    logic           apply_wait;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int            m_pos;
    bit            m_pend;
    logic [NS-1:0] m_shadow;

    always #2 clk = ~clk;

    acs_inserter u_dut (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .c_in(c_in),
        .regen_en(regen_en), .apply(apply), .host_reg(host_reg),
        .out_valid(out_valid), .z_out(z_out), .c_out(c_out), .apply_wait(apply_wait)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (pos %0d)", req, act, exp, m_pos);
        end
    endtask

    function automatic logic [7:0] crc_ref(input logic [NS-1:0] d);
        logic [7:0] c;
        logic f;
        c = 8'hFF;
        for (int i = 0; i < NS; i++) begin
            f = d[i] ^ c[7];
            c = {c[6:0], 1'b0};
            if (f) c = c ^ 8'h1D;
        end
        return c;
    endfunction

    function automatic logic [NS-1:0] make_pat(input int seed);
        logic [NS-1:0] d;
        for (int i = 0; i < NS; i++) d[i] = (((i * seed) + (seed >> 1) + i / 5) % 7) < 3;
        return d;
    endfunction

    task automatic do_frame(input logic [NCH-1:0] cin, input bit ap);
        logic          ebit;
        logic [7:0]    ecrc;
        logic [NCH-1:0] exp_c;
        bit            bnd;
        @(negedge clk);
        frame_valid = 1'b1;
        c_in        = cin;
        apply       = ap;
        ecrc = crc_ref(m_shadow);
        ebit = (m_pos < NS) ? m_shadow[m_pos] : ecrc[m_pos - NS];
        exp_c = regen_en ? {NCH{ebit}} : cin;
        bnd = (m_pos == NF - 1);
        if (bnd && (m_pend || ap)) begin
            m_shadow = host_reg;
            m_pend   = 1'b0;
        end else begin
            m_pend = m_pend | ap;
        end
        @(negedge clk);
        frame_valid = 1'b0;
        apply       = 1'b0;
        c_in        = '0;
        check(out_valid == 1'b1, "R2", 32'(out_valid), 32'd1);
        check(z_out == (m_pos == 0), "R3", 32'(z_out), 32'(m_pos == 0));
        if (!regen_en)      check(c_out == exp_c, "R4", 32'(c_out), 32'(exp_c));
        else if (m_pos < NS) check(c_out == exp_c, "R5", 32'(c_out), 32'(exp_c));
        else                check(c_out == exp_c, "R6", 32'(c_out), 32'(exp_c));
        if (bnd && ap)      check(apply_wait == m_pend, "R9", 32'(apply_wait), 32'(m_pend));
        else                check(apply_wait == m_pend, "R7", 32'(apply_wait), 32'(m_pend));
        m_pos = (m_pos + 1) % NF;
        for (int g = 0; g < (m_pos % 3); g++) begin
            @(negedge clk);
            check(!out_valid && !z_out && c_out == '0, "R2", 32'(out_valid), 32'd0);
        end
    endtask

    task automatic run_block(input int blk, input logic [NS-1:0] mid_host, input int mid_at,
                             input int apply_at, input int off_lo, input int off_hi);
        bit keep;
        for (int p = 0; p < NF; p++) begin
            if (p == mid_at) host_reg = mid_host;
            keep = regen_en;
            if (p >= off_lo && p < off_hi) regen_en = 1'b0;   // R10
            do_frame(8'((p * 37) ^ 8'h5A ^ blk), p == apply_at);
            regen_en = keep;
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [NS-1:0] pa, pa2, pb, pc;
        pa  = make_pat(11);
        pa2 = make_pat(23);
        pb  = make_pat(5);
        pc  = make_pat(17);
        rst = 1'b1; frame_valid = 1'b0; c_in = '0; regen_en = 1'b0; apply = 1'b0; host_reg = pa;
        m_pos = 0; m_pend = 1'b0; m_shadow = '0;
        repeat (3) @(negedge clk);
        check(!out_valid && !z_out && c_out == '0 && !apply_wait, "R1", 32'(c_out), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !z_out && c_out == '0 && !apply_wait, "R1", 32'(out_valid), 32'd0);

        // Block 0: pass-through, apply at 20, host rewritten at 100 before boundary (R8)
        run_block(0, pa2, 100, 20, -1, -1);
        // Block 1: regenerated from pa2; host changed without apply (R8)
        regen_en = 1'b1;
        run_block(1, pb, 50, -1, -1, -1);
        // Block 2: still pa2; apply exactly at the boundary frame with pc (R9)
        run_block(2, pc, 0, NF - 1, -1, -1);
        // Block 3: pc, regen off on frames 60..69 (R10)
        run_block(3, pc, -1, -1, 60, 70);
        // Standalone apply between frames raises wait (R7), then reset clears it (R1)
        @(negedge clk); apply = 1'b1;
        @(negedge clk); apply = 1'b0;
        check(apply_wait == 1'b1, "R7", 32'(apply_wait), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!apply_wait && !out_valid, "R1", 32'(apply_wait), 32'd0);
        m_pos = 0; m_pend = 1'b0; m_shadow = '0;
        // Block 4: shadow cleared by reset, so zeros then CRC of zeros (R1, R6)
        run_block(4, pc, -1, -1, -1, -1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule